// File: doc/BRIEF.md
# DMA Channel Register File

This block is the byte-wide, I/O-mapped configuration front end of a four-channel DMA controller. A host writes and reads 8-bit values at sixteen port offsets. It programs a 16-bit start address and a 16-bit transfer count for each channel, a per-channel mode, a per-channel request mask and a global command byte. It reads back a status byte that gathers terminal-count events and pending requests reported by the transfer engine.

The 16-bit address and count registers sit behind one byte-wide port each. A single shared byte pointer decides whether an access hits the low byte or the high byte. The pointer flips after every such access. The host returns it to the low byte by writing anything to a dedicated clear port. The mode and single-mask ports carry the target channel in the two low bits of the written byte, so one port serves all four channels.

The outputs of the block are the stored configuration and the mask state. They feed a transfer engine, which reports terminal-count pulses and request levels back to the block.

Top module: `dmaregs_top`

## Requirements
- R1: After reset, all addresses, counts, modes and the command byte are zero, all four channel masks are set (chan_mask_o = 4'hF), ctrl_off_o is 0, the status byte is zero and the byte pointer selects the low byte.
- R2: Offset 2n accesses channel n's address register and offset 2n+1 accesses its count register, for n = 0 to 3.
- R3: Each read or write of offsets 0 to 7 reaches the low byte when the pointer is low and the high byte when it is high, and then flips the pointer. A write of any value to offset 12 sets the pointer to low.
- R4: A write to offset 10 selects a channel with bits [1:0] and loads that channel's mask with bit 2 (1 = masked, 0 = unmasked). Other channels keep their masks.
- R5: A write to offset 15 loads all four masks at once: bit n drives channel n's mask, and bits [7:4] are ignored.
- R6: A write to offset 11 selects a channel with bits [1:0] and stores bits [7:2] as that channel's 6-bit mode: mode[1:0] = transfer type (00 verify, 01 write, 10 read), mode[2] = auto-initialize, mode[3] = address decrement, mode[5:4] = service mode (00 demand, 01 single, 10 block, 11 cascade).
- R7: A write to offset 8 loads the command byte, and ctrl_off_o equals command bit 2 from the next cycle on.
- R8: A read of offset 8 returns {request bits, terminal-count bits}. Bit n of tc_i sets status bit n, and that bit stays set until a status read clears it. A pulse that arrives in the same cycle as the clearing read is kept. Status bits [7:4] follow req_i one cycle late, and a read does not clear them.
- R9: A write to offset 13 sets the pointer to low, clears the status byte and sets all four masks. Addresses, counts, modes and the command byte keep their values.
- R10: rdata_o is zero when rd_i is low and zero for reads of offsets 9 to 15. When wr_i and rd_i are both high, the write takes place and the read has no side effect of its own.
- R11: Writes to offsets 9 and 14 change no register and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 4 | Port offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| tc_i | input | 4 | Terminal-count pulses from the transfer engine, one per channel |
| req_i | input | 4 | Request levels from the transfer engine, one per channel |
| rdata_o | output | 8 | Read data (combinational) |
| base_addr_o | output | 64 | Channel start addresses, channel n in bits [16n+15:16n] |
| base_cnt_o | output | 64 | Channel transfer counts, channel n in bits [16n+15:16n] |
| chan_mode_o | output | 24 | Channel modes, channel n in bits [6n+5:6n] |
| chan_mask_o | output | 4 | Request mask per channel, 1 = masked |
| ctrl_off_o | output | 1 | Controller disable (command bit 2) |

## Verification
Several properties are checked on every cycle. The byte pointer flips on each data-port access and returns to low on a clear. Terminal-count flags never drop without a status read or master reset. A master reset leaves all masks set and the status empty. Registers hold when they are not written, and the disable output follows the command byte. Only the bench scenarios can show that the right byte of the right channel is reached through the shared pointer and that readback returns the stored bytes. They also cover the same-cycle collisions: a pulse during a clearing read, and a write together with a read. Reserved offsets are shown to leave every observable value unchanged.

// File: rtl/dmaregs_pkg.sv
// Shared constants and types for the DMA channel register file.
// Assumes four channels addressed by a 2-bit field and 4-bit port offsets.
package dmaregs_pkg;
    localparam int NCH = 4;
    localparam int BW  = 8;
    localparam int WW  = 16;
    localparam int AW  = 4;
    localparam int MW  = 6;
    localparam int CSW = $clog2(NCH);

    typedef enum logic [AW-1:0] {
        PORT_CMD_STAT = 4'd8,
        PORT_REQ      = 4'd9,
        PORT_SMASK    = 4'd10,
        PORT_MODE     = 4'd11,
        PORT_PTRCLR   = 4'd12,
        PORT_MRST     = 4'd13,
        PORT_MASKCLR  = 4'd14,
        PORT_MMASK    = 4'd15
    } port_e;

    typedef struct packed {
        logic [1:0] svc;
        logic       dec;
        logic       autoi;
        logic [1:0] xfer;
    } mode_t;
endpackage

// File: rtl/dmaregs_ptr.sv
// Shared low/high byte pointer.
// Assumes clear and toggle may coincide; clear wins.
module dmaregs_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tog_i,
    output logic hi_o
);
    // Pointer state: cleared by reset or clear, flipped on each data access.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_o <= 1'b0;
        else if (clr_i) hi_o <= 1'b0;
        else if (tog_i) hi_o <= ~hi_o;
    end

    a_r3_ptr_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && tog_i) |=> (hi_o != $past(hi_o)));
    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hi_o);
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tog_i) |=> $stable(hi_o));
endmodule

// File: rtl/dmaregs_chan.sv
// Register set of one channel: address, count, mode and mask.
// Assumes the top decodes offsets; the mask force (master reset) wins over loads.
module dmaregs_chan
    import dmaregs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we_i,
    input  logic          cnt_we_i,
    input  logic          hi_i,
    input  logic [BW-1:0] wdata_i,
    input  logic          mode_we_i,
    input  logic          mask_we_i,
    input  logic          mask_val_i,
    input  logic          mask_force_i,
    output logic [WW-1:0] base_addr_o,
    output logic [WW-1:0] base_cnt_o,
    output mode_t         mode_o,
    output logic          mask_o
);
    // Address register: byte selected by the shared pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_addr_o <= '0;
        else if (addr_we_i) begin
            if (hi_i) base_addr_o[WW-1:BW] <= wdata_i;
            else      base_addr_o[BW-1:0]  <= wdata_i;
        end
    end

    // Count register: byte selected by the shared pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)        base_cnt_o <= '0;
        else if (cnt_we_i) begin
            if (hi_i) base_cnt_o[WW-1:BW] <= wdata_i;
            else      base_cnt_o[BW-1:0]  <= wdata_i;
        end
    end

    // Mode register: upper six bits of the mode byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_o <= '0;
        else if (mode_we_i) mode_o <= mode_t'(wdata_i[BW-1:2]);
    end

    // Request mask: set at reset and master reset, otherwise loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)            mask_o <= 1'b1;
        else if (mask_force_i) mask_o <= 1'b1;
        else if (mask_we_i)    mask_o <= mask_val_i;
    end

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_we_i |=> $stable(base_addr_o));
    a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we_i |=> $stable(base_cnt_o));
    a_r9_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
        mask_force_i |=> mask_o);
    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && !mask_force_i) |=> (mask_o == $past(mask_val_i)));
endmodule

// File: rtl/dmaregs_status.sv
// Status byte: sticky terminal-count flags and registered request levels.
// Assumes a new pulse wins over a clearing read, and master reset wins over both.
module dmaregs_status
    import dmaregs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc_i,
    input  logic [NCH-1:0] req_i,
    input  logic           rd_clr_i,
    input  logic           mrst_i,
    output logic [BW-1:0]  status_o
);
    logic [NCH-1:0] tc_q, req_q;

    // Terminal-count flags: set by pulses, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || mrst_i) tc_q <= '0;
        else                  tc_q <= (rd_clr_i ? '0 : tc_q) | tc_i;
    end

    // Request flags: one-cycle copy of the request levels.
    always_ff @(posedge clk) begin
        if (!rst_n || mrst_i) req_q <= '0;
        else                  req_q <= req_i;
    end

    assign status_o = {req_q, tc_q};

    a_r8_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && !mrst_i) |=> ((tc_q & $past(tc_q)) == $past(tc_q)));
    a_r8_tc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !mrst_i && tc_i == '0) |=> (tc_q == '0));
    a_r9_status_empty: assert property (@(posedge clk) disable iff (!rst_n)
        mrst_i |=> (status_o == '0));
endmodule

// File: rtl/dmaregs_top.sv
// DMA channel register file: decodes port offsets, routes bytes through the
// shared pointer to the channel registers and builds the read data.
// Assumes one access per cycle; a write together with a read acts as a write.
module dmaregs_top
    import dmaregs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [BW-1:0]      wdata_i,
    input  logic [NCH-1:0]     tc_i,
    input  logic [NCH-1:0]     req_i,
    output logic [BW-1:0]      rdata_o,
    output logic [NCH*WW-1:0]  base_addr_o,
    output logic [NCH*WW-1:0]  base_cnt_o,
    output logic [NCH*MW-1:0]  chan_mode_o,
    output logic [NCH-1:0]     chan_mask_o,
    output logic               ctrl_off_o
);
    logic           data_port, rd_only, ptr_hi, ptr_clr, ptr_tog;
    logic           mrst, stat_clr, smask_we, mmask_we;
    logic [BW-1:0]  cmd_q, status;
    logic [WW-1:0]  ch_addr [NCH];
    logic [WW-1:0]  ch_cnt  [NCH];
    logic [WW-1:0]  sel_word;
    logic [CSW-1:0] sel_ch;

    // Access classification shared by pointer, status and channels.
    always_comb begin
        data_port = (addr_i < AW'(2*NCH));
        rd_only   = rd_i && !wr_i;
        mrst      = wr_i && (addr_i == PORT_MRST);
        ptr_clr   = mrst || (wr_i && (addr_i == PORT_PTRCLR));
        ptr_tog   = data_port && (wr_i || rd_i);
        stat_clr  = rd_only && (addr_i == PORT_CMD_STAT);
        smask_we  = wr_i && (addr_i == PORT_SMASK);
        mmask_we  = wr_i && (addr_i == PORT_MMASK);
    end

    // Command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cmd_q <= '0;
        else if (wr_i && addr_i == PORT_CMD_STAT)  cmd_q <= wdata_i;
    end
    assign ctrl_off_o = cmd_q[2];

    dmaregs_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ptr_clr),
        .tog_i (ptr_tog),
        .hi_o  (ptr_hi)
    );

    dmaregs_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_i     (tc_i),
        .req_i    (req_i),
        .rd_clr_i (stat_clr),
        .mrst_i   (mrst),
        .status_o (status)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic  a_we, c_we, m_we, k_we, k_val;
        mode_t mode;

        // Per-channel decode of data, mode and mask writes.
        always_comb begin
            a_we  = wr_i && (addr_i == AW'(2*n));
            c_we  = wr_i && (addr_i == AW'(2*n+1));
            m_we  = wr_i && (addr_i == PORT_MODE) && (wdata_i[CSW-1:0] == CSW'(n));
            k_we  = mmask_we || (smask_we && (wdata_i[CSW-1:0] == CSW'(n)));
            k_val = mmask_we ? wdata_i[n] : wdata_i[2];
        end

        dmaregs_chan u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .addr_we_i    (a_we),
            .cnt_we_i     (c_we),
            .hi_i         (ptr_hi),
            .wdata_i      (wdata_i),
            .mode_we_i    (m_we),
            .mask_we_i    (k_we),
            .mask_val_i   (k_val),
            .mask_force_i (mrst),
            .base_addr_o  (ch_addr[n]),
            .base_cnt_o   (ch_cnt[n]),
            .mode_o       (mode),
            .mask_o       (chan_mask_o[n])
        );

        assign base_addr_o[n*WW +: WW] = ch_addr[n];
        assign base_cnt_o[n*WW +: WW]  = ch_cnt[n];
        assign chan_mode_o[n*MW +: MW] = mode;
    end

    // Read data: selected byte of a data register, or the status byte.
    always_comb begin
        sel_ch   = addr_i[CSW:1];
        sel_word = addr_i[0] ? ch_cnt[sel_ch] : ch_addr[sel_ch];
        rdata_o  = '0;
        if (rd_i) begin
            if (data_port)                    rdata_o = ptr_hi ? sel_word[WW-1:BW] : sel_word[BW-1:0];
            else if (addr_i == PORT_CMD_STAT) rdata_o = status;
        end
    end

    a_r7_cmd_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == PORT_CMD_STAT) |=> (ctrl_off_o == $past(wdata_i[2])));
    a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (chan_mask_o == '1));
    a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/dmaregs_top_bench.sv
`timescale 1ns/1ps
module dmaregs_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        wr, rd;
    logic [7:0]  wdata;
    logic [3:0]  tc, req;
    logic [7:0]  rdata;
    logic [63:0] b_addr, b_cnt;
    logic [23:0] c_mode;
    logic [3:0]  c_mask;
    logic        c_off;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [5:0]  m_mode [4];
    logic [3:0]  m_mask, m_tc, m_req;
    logic [7:0]  m_cmd;
    logic        m_hi;

    always #2.5 clk = ~clk;

    dmaregs_top u_dmaregs_top (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .tc_i(tc), .req_i(req), .rdata_o(rdata),
        .base_addr_o(b_addr), .base_cnt_o(b_cnt), .chan_mode_o(c_mode),
        .chan_mask_o(c_mask), .ctrl_off_o(c_off)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [15:0] w;
        if (a < 4'd8) begin
            w = a[0] ? m_cnt[a[2:1]] : m_addr[a[2:1]];
            return m_hi ? w[15:8] : w[7:0];
        end
        if (a == 4'd8) return {m_req, m_tc};
        return 8'h00;
    endfunction

    function automatic logic [63:0] pack_w(input bit cnt);
        logic [63:0] v;
        for (int n = 0; n < 4; n++) v[n*16 +: 16] = cnt ? m_cnt[n] : m_addr[n];
        return v;
    endfunction

    function automatic logic [23:0] pack_m();
        logic [23:0] v;
        for (int n = 0; n < 4; n++) v[n*6 +: 6] = m_mode[n];
        return v;
    endfunction

    // Reference update at a clock edge, written from the requirements.
    task automatic model_edge(input bit w, input bit r, input logic [3:0] a,
                              input logic [7:0] d, input logic [3:0] t, input logic [3:0] q);
        bit mr = 0, clr = 0;
        if (w) begin
            if (a < 4'd8) begin
                if (a[0]) begin if (m_hi) m_cnt[a[2:1]][15:8] = d; else m_cnt[a[2:1]][7:0] = d; end
                else      begin if (m_hi) m_addr[a[2:1]][15:8] = d; else m_addr[a[2:1]][7:0] = d; end
                m_hi = ~m_hi;
            end else case (a)
                4'd8:  m_cmd = d;
                4'd10: m_mask[d[1:0]] = d[2];
                4'd11: m_mode[d[1:0]] = d[7:2];
                4'd12: m_hi = 0;
                4'd13: begin m_hi = 0; m_mask = 4'hF; mr = 1; end
                4'd15: m_mask = d[3:0];
                default: ;
            endcase
        end else if (r) begin
            if (a < 4'd8) m_hi = ~m_hi;
            else if (a == 4'd8) clr = 1;
        end
        if (mr) begin m_tc = 0; m_req = 0; end
        else begin m_tc = (clr ? 4'h0 : m_tc) | t; m_req = q; end
    endtask

    task automatic check_all(input string tag);
        check({tag, " addr"}, b_addr, pack_w(0));
        check({tag, " cnt"},  b_cnt,  pack_w(1));
        check({tag, " mode"}, {40'd0, c_mode}, {40'd0, pack_m()});
        check({tag, " mask"}, {60'd0, c_mask}, {60'd0, m_mask});
        check({tag, " off"},  {63'd0, c_off},  {63'd0, m_cmd[2]});
    endtask

    task automatic op(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d,
                      input logic [3:0] t, input logic [3:0] q, input string tag);
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; tc = t; req = q;
        #1;
        if (r && !w) check({tag, " rdata"}, {56'd0, rdata}, {56'd0, exp_rd(a)});
        @(posedge clk);
        model_edge(w, r, a, d, t, q);
        #1;
        wr = 0; rd = 0; tc = 0;
        check_all(tag);
    endtask

    task automatic wr_op(input logic [3:0] a, input logic [7:0] d, input string tag);
        op(1, 0, a, d, 4'h0, req, tag);
    endtask

    task automatic rd_op(input logic [3:0] a, input string tag);
        op(0, 1, a, 8'h00, 4'h0, req, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7219));
        rst_n = 0; wr = 0; rd = 0; addr = 0; wdata = 0; tc = 0; req = 0;
        for (int n = 0; n < 4; n++) begin m_addr[n] = 0; m_cnt[n] = 0; m_mode[n] = 0; end
        m_mask = 4'hF; m_tc = 0; m_req = 0; m_cmd = 0; m_hi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        check_all("R1");
        rd_op(4'd8, "R1 status");

        // R2, R3: channel 2 address at offset 4, channel 1 count at offset 3
        wr_op(4'd12, 8'h00, "R3 clear");
        wr_op(4'd4, 8'h34, "R2 lo");
        wr_op(4'd4, 8'h12, "R2 hi");
        check("R2 ch2 addr", {48'd0, b_addr[47:32]}, 64'h1234);
        wr_op(4'd3, 8'hCD, "R2 cnt lo");
        wr_op(4'd3, 8'hAB, "R2 cnt hi");
        check("R2 ch1 cnt", {48'd0, b_cnt[31:16]}, 64'hABCD);
        // R3: clear mid-sequence returns to low byte
        wr_op(4'd0, 8'h11, "R3 lo");
        wr_op(4'd12, 8'h5A, "R3 clear");
        wr_op(4'd0, 8'h22, "R3 lo again");
        check("R3 ch0 addr", {48'd0, b_addr[15:0]}, 64'h0022);
        wr_op(4'd12, 8'h00, "R3 clear");
        // R10 readback byte by byte
        rd_op(4'd4, "R10 read lo");
        rd_op(4'd4, "R10 read hi");
        rd_op(4'd9, "R10 reserved read");
        // R4 single mask
        wr_op(4'd10, 8'h02, "R4 unmask ch2");
        check("R4 mask", {60'd0, c_mask}, 64'hB);
        wr_op(4'd10, 8'h06, "R4 mask ch2");
        // R5 multi mask, upper bits ignored
        wr_op(4'd15, 8'hF5, "R5 multi");
        check("R5 mask", {60'd0, c_mask}, 64'h5);
        // R6 mode
        wr_op(4'd11, 8'hD6, "R6 mode");
        check("R6 ch2 mode", {58'd0, c_mode[17:12]}, 64'h35);
        // R7 command
        wr_op(4'd8, 8'h04, "R7 disable");
        check("R7 off", {63'd0, c_off}, 64'd1);
        wr_op(4'd8, 8'h00, "R7 enable");
        // R8 status
        req = 4'hA;
        op(0, 0, 4'd0, 8'h00, 4'h2, 4'hA, "R8 tc pulse");
        rd_op(4'd8, "R8 status read");
        rd_op(4'd8, "R8 status cleared");
        op(0, 1, 4'd8, 8'h00, 4'h4, 4'hA, "R8 pulse during read");
        rd_op(4'd8, "R8 pulse kept");
        // R11 reserved writes
        wr_op(4'd9, 8'hFF, "R11 port9");
        wr_op(4'd14, 8'hFF, "R11 port14");
        rd_op(4'd4, "R11 pointer unmoved");
        wr_op(4'd12, 8'h00, "R3 clear");
        // R10 write with read
        op(1, 1, 4'd6, 8'h77, 4'h0, req, "R10 write and read");
        rd_op(4'd6, "R10 pointer after wr+rd");
        // R9 master reset
        op(0, 0, 4'd0, 8'h00, 4'h8, 4'h3, "R9 prep");
        wr_op(4'd13, 8'h00, "R9 master reset");
        rd_op(4'd8, "R9 status");

        // Constrained random traffic
        for (int i = 0; i < 1500; i++) begin
            logic [3:0] a = 4'($urandom_range(0, 15));
            int         k = $urandom_range(0, 9);
            bit         w = (k < 5);
            bit         r = (k >= 5 && k < 9) || (k == 9 && a < 4'd8);
            if (k == 9) w = 1;
            op(w, r, a, 8'($urandom), 4'($urandom), 4'($urandom), "random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule